// File: doc/BRIEF.md
# Five-Stage Pipeline Boundary Registers

This block holds the four boundary registers of a five-stage 32-bit RISC pipeline. These are fetch/decode, decode/execute, execute/memory and memory/writeback. It also holds the program counter and the next-PC choice made in fetch. The surrounding logic is outside this block and reaches it only through ports. That logic is the instruction memory, register file, decoder, ALU and data memory. Each stage drives its own results into the block and reads back what the previous boundary latched.

The control word from the decoder comes in three groups. The execute group is used in execute and dropped there. The memory group is carried one boundary further. The writeback group goes all the way to the last register. The instruction's PC and its destination register number ride along with the data, so that a later stage can still use them after the fetch register has moved on to younger instructions.

The back-pressure is a single `stall` pin rather than a valid/ready pair. While `stall` is high, the PC and the fetch/decode register keep their contents, and the decode/execute register takes a bubble. Later boundaries keep draining. Each boundary also has its own kill input, and a redirect pin selects a branch target as the next PC.

Top module: `pipe_stage_regs`

## Requirements
- R1: A synchronous active-high `rst` makes, on the next rising edge:
  - `pc_q` equal to RESET_PC (default 0);
  - `ifid_instr` and `ifid_pc` zero;
  - every control output (`ex_ctl_*`, `mem_ctl_*`, `wb_ctl_wb`) zero.
- R2: With `rst`, `stall` and `pc_sel_branch` low, `pc_q` increases by 4 on each rising edge, wrapping modulo 2^32.
- R3: When `pc_sel_branch` is high, `pc_q` takes `branch_target` on the next edge, whether or not `stall` is high.
- R4: On a cycle with no `stall`, no `flush_ifid` and no reset, `ifid_instr` takes `imem_instr` and `ifid_pc` takes the current `pc_q`.
- R5: While `stall` is high, `pc_q` holds unless R3 applies, and `ifid_instr`/`ifid_pc` hold unless R7 applies.
- R6: When `stall` or `bubble_idex` is high, all three decode/execute control outputs become zero on the next edge, while its data outputs still load as in R8.
- R7: When `flush_ifid` is high, `ifid_instr` becomes 0 (the no-op encoding) and `ifid_pc` takes `pc_q`. This holds even when `stall` is high.
- R8: The decode/execute register loads these values:
  - `ex_rs_val`, `ex_rt_val`, `ex_imm` and `ex_dest` from the `id_*` inputs;
  - `ex_pc` from `ifid_pc`;
  - the three control groups, whose bit layouts are: execute `{alu_src, alu_op[1:0], reg_dst}` (4 bits), memory `{branch, mem_read, mem_write}` (3 bits), writeback `{mem_to_reg, reg_write}` (2 bits).
- R9: The execute/memory register loads these values:
  - `mem_alu_res`, `mem_br_target`, `mem_zero` and `mem_store_data` from the `ex_*` inputs;
  - `mem_dest` from `ex_dest`;
  - its memory and writeback groups from `ex_ctl_m`/`ex_ctl_wb`. `bubble_exmem` zeroes those two groups instead.
- R10: The memory/writeback register loads these values:
  - `wb_load_data` from `mem_load_data`;
  - `wb_alu_res` from `mem_alu_res`;
  - `wb_dest` from `mem_dest`;
  - `wb_ctl_wb` from `mem_ctl_wb`, or zero when `bubble_memwb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold PC and fetch/decode, bubble decode/execute |
| flush_ifid | input | 1 | Replace fetch/decode instruction with no-op |
| bubble_idex | input | 1 | Zero decode/execute control |
| bubble_exmem | input | 1 | Zero execute/memory control |
| bubble_memwb | input | 1 | Zero memory/writeback control |
| pc_sel_branch | input | 1 | Select branch target as next PC |
| branch_target | input | 32 | Redirect address |
| pc_q | output | 32 | Current fetch PC |
| imem_instr | input | 32 | Instruction fetched at pc_q |
| ifid_instr | output | 32 | Latched instruction |
| ifid_pc | output | 32 | PC of latched instruction |
| id_rs_val | input | 32 | First register read value |
| id_rt_val | input | 32 | Second register read value |
| id_imm | input | 32 | Sign-extended offset |
| id_dest | input | 5 | Destination register number |
| id_ctl_ex | input | 4 | Execute control group |
| id_ctl_m | input | 3 | Memory control group |
| id_ctl_wb | input | 2 | Writeback control group |
| ex_rs_val | output | 32 | Latched first operand |
| ex_rt_val | output | 32 | Latched second operand |
| ex_imm | output | 32 | Latched offset |
| ex_pc | output | 32 | PC in execute |
| ex_dest | output | 5 | Destination in execute |
| ex_ctl_ex | output | 4 | Execute control group |
| ex_ctl_m | output | 3 | Memory group in execute |
| ex_ctl_wb | output | 2 | Writeback group in execute |
| ex_alu_res | input | 32 | ALU result |
| ex_br_target | input | 32 | Computed branch address |
| ex_zero | input | 1 | ALU zero flag |
| ex_store_data | input | 32 | Store data |
| mem_alu_res | output | 32 | Address/result in memory stage |
| mem_br_target | output | 32 | Branch address in memory stage |
| mem_zero | output | 1 | Zero flag in memory stage |
| mem_store_data | output | 32 | Store data in memory stage |
| mem_dest | output | 5 | Destination in memory stage |
| mem_ctl_m | output | 3 | Memory control group |
| mem_ctl_wb | output | 2 | Writeback group in memory stage |
| mem_load_data | input | 32 | Data memory read value |
| wb_load_data | output | 32 | Loaded data in writeback |
| wb_alu_res | output | 32 | ALU result in writeback |
| wb_dest | output | 5 | Register to write |
| wb_ctl_wb | output | 2 | Writeback control group |

## Verification
The assertions take for granted that every input is a known 0/1 value at each rising edge and does not change at that edge. The hold properties also assume that a redirect or flush in the same cycle is allowed to win; each such property therefore excludes those cases in its antecedent rather than assuming they never occur. The stimulus changes every input only on the falling clock edge, with random values. It runs in phases that raise stall, flush, redirect and the three bubble pins together and alone, including stall combined with flush and stall combined with redirect, plus a reset pulse in mid-stream.

// File: rtl/pipe_regs_pkg.sv
package pipe_regs_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned EX_CTL_W  = 4;  // {alu_src, alu_op[1:0], reg_dst}
  localparam int unsigned M_CTL_W   = 3;  // {branch, mem_read, mem_write}
  localparam int unsigned WB_CTL_W  = 2;  // {mem_to_reg, reg_write}
  localparam int unsigned PC_STEP   = 4;

  typedef logic [XLEN-1:0] word_t;
endpackage

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int unsigned XW = pipe_regs_pkg::XLEN,
  parameter logic [XW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          sel_target,
  input  logic [XW-1:0] target,
  output logic [XW-1:0] pc_q
);
  localparam logic [XW-1:0] STEP = XW'(pipe_regs_pkg::PC_STEP);

  always_ff @(posedge clk) begin
    if (rst)             pc_q <= RESET_PC;
    else if (sel_target) pc_q <= target;
    else if (!hold)      pc_q <= pc_q + STEP;
  end
endmodule

// File: rtl/ifid_reg.sv
module ifid_reg #(
  parameter int unsigned XW = pipe_regs_pkg::XLEN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          flush,
  input  logic [XW-1:0] instr_d,
  input  logic [XW-1:0] pc_d,
  output logic [XW-1:0] instr_q,
  output logic [XW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q <= '0;
      pc_q    <= '0;
    end else if (flush) begin
      instr_q <= '0;
      pc_q    <= pc_d;
    end else if (!hold) begin
      instr_q <= instr_d;
      pc_q    <= pc_d;
    end
  end
endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
  parameter int unsigned CW = 2,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bubble,
  input  logic [CW-1:0] ctl_d,
  input  logic [DW-1:0] data_d,
  output logic [CW-1:0] ctl_q,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst || bubble) ctl_q <= '0;
    else               ctl_q <= ctl_d;
  end

  always_ff @(posedge clk) begin
    data_q <= data_d;
  end
endmodule

// File: rtl/pipe_stage_regs.sv
module pipe_stage_regs #(
  parameter int unsigned XW = pipe_regs_pkg::XLEN,
  parameter int unsigned RW = pipe_regs_pkg::REG_IDX_W,
  parameter int unsigned EW = pipe_regs_pkg::EX_CTL_W,
  parameter int unsigned MW = pipe_regs_pkg::M_CTL_W,
  parameter int unsigned WW = pipe_regs_pkg::WB_CTL_W,
  parameter logic [XW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          flush_ifid,
  input  logic          bubble_idex,
  input  logic          bubble_exmem,
  input  logic          bubble_memwb,
  input  logic          pc_sel_branch,
  input  logic [XW-1:0] branch_target,
  output logic [XW-1:0] pc_q,
  input  logic [XW-1:0] imem_instr,
  output logic [XW-1:0] ifid_instr,
  output logic [XW-1:0] ifid_pc,
  input  logic [XW-1:0] id_rs_val,
  input  logic [XW-1:0] id_rt_val,
  input  logic [XW-1:0] id_imm,
  input  logic [RW-1:0] id_dest,
  input  logic [EW-1:0] id_ctl_ex,
  input  logic [MW-1:0] id_ctl_m,
  input  logic [WW-1:0] id_ctl_wb,
  output logic [XW-1:0] ex_rs_val,
  output logic [XW-1:0] ex_rt_val,
  output logic [XW-1:0] ex_imm,
  output logic [XW-1:0] ex_pc,
  output logic [RW-1:0] ex_dest,
  output logic [EW-1:0] ex_ctl_ex,
  output logic [MW-1:0] ex_ctl_m,
  output logic [WW-1:0] ex_ctl_wb,
  input  logic [XW-1:0] ex_alu_res,
  input  logic [XW-1:0] ex_br_target,
  input  logic          ex_zero,
  input  logic [XW-1:0] ex_store_data,
  output logic [XW-1:0] mem_alu_res,
  output logic [XW-1:0] mem_br_target,
  output logic          mem_zero,
  output logic [XW-1:0] mem_store_data,
  output logic [RW-1:0] mem_dest,
  output logic [MW-1:0] mem_ctl_m,
  output logic [WW-1:0] mem_ctl_wb,
  input  logic [XW-1:0] mem_load_data,
  output logic [XW-1:0] wb_load_data,
  output logic [XW-1:0] wb_alu_res,
  output logic [RW-1:0] wb_dest,
  output logic [WW-1:0] wb_ctl_wb
);
  localparam int unsigned IDEX_CW  = EW + MW + WW;
  localparam int unsigned IDEX_DW  = 4*XW + RW;
  localparam int unsigned EXMEM_CW = MW + WW;
  localparam int unsigned EXMEM_DW = 3*XW + 1 + RW;
  localparam int unsigned MEMWB_CW = WW;
  localparam int unsigned MEMWB_DW = 2*XW + RW;

  // fetch
  pc_unit #(.XW(XW), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst(rst), .hold(stall), .sel_target(pc_sel_branch),
    .target(branch_target), .pc_q(pc_q)
  );

  ifid_reg #(.XW(XW)) u_ifid (
    .clk(clk), .rst(rst), .hold(stall), .flush(flush_ifid),
    .instr_d(imem_instr), .pc_d(pc_q),
    .instr_q(ifid_instr), .pc_q(ifid_pc)
  );

  // decode -> execute
  logic [IDEX_CW-1:0] idex_ctl_q;
  logic [IDEX_DW-1:0] idex_data_q;

  stage_reg #(.CW(IDEX_CW), .DW(IDEX_DW)) u_idex (
    .clk(clk), .rst(rst), .bubble(stall || bubble_idex),
    .ctl_d({id_ctl_ex, id_ctl_m, id_ctl_wb}),
    .data_d({id_rs_val, id_rt_val, id_imm, ifid_pc, id_dest}),
    .ctl_q(idex_ctl_q), .data_q(idex_data_q)
  );
  assign {ex_ctl_ex, ex_ctl_m, ex_ctl_wb}              = idex_ctl_q;
  assign {ex_rs_val, ex_rt_val, ex_imm, ex_pc, ex_dest} = idex_data_q;

  // execute -> memory: execute group dropped here
  logic [EXMEM_CW-1:0] exmem_ctl_q;
  logic [EXMEM_DW-1:0] exmem_data_q;

  stage_reg #(.CW(EXMEM_CW), .DW(EXMEM_DW)) u_exmem (
    .clk(clk), .rst(rst), .bubble(bubble_exmem),
    .ctl_d({ex_ctl_m, ex_ctl_wb}),
    .data_d({ex_alu_res, ex_br_target, ex_zero, ex_store_data, ex_dest}),
    .ctl_q(exmem_ctl_q), .data_q(exmem_data_q)
  );
  assign {mem_ctl_m, mem_ctl_wb} = exmem_ctl_q;
  assign {mem_alu_res, mem_br_target, mem_zero, mem_store_data, mem_dest} = exmem_data_q;

  // memory -> writeback: only writeback group survives
  logic [MEMWB_CW-1:0] memwb_ctl_q;
  logic [MEMWB_DW-1:0] memwb_data_q;

  stage_reg #(.CW(MEMWB_CW), .DW(MEMWB_DW)) u_memwb (
    .clk(clk), .rst(rst), .bubble(bubble_memwb),
    .ctl_d(mem_ctl_wb),
    .data_d({mem_load_data, mem_alu_res, mem_dest}),
    .ctl_q(memwb_ctl_q), .data_q(memwb_data_q)
  );
  assign wb_ctl_wb = memwb_ctl_q;
  assign {wb_load_data, wb_alu_res, wb_dest} = memwb_data_q;

  // checks
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!stall && !pc_sel_branch) |=> pc_q == $past(pc_q) + XW'(4)); // R2
  AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    pc_sel_branch |=> pc_q == $past(branch_target)); // R3
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stall && !pc_sel_branch) |=> $stable(pc_q)); // R5
  AST_IFID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush_ifid) |=> ($stable(ifid_instr) && $stable(ifid_pc))); // R5
  AST_IFID_FLUSH_NOP: assert property (@(posedge clk) disable iff (rst)
    flush_ifid |=> (ifid_instr == '0 && ifid_pc == $past(pc_q))); // R7
  AST_IDEX_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (stall || bubble_idex) |=> (ex_ctl_ex == '0 && ex_ctl_m == '0 && ex_ctl_wb == '0)); // R6
  AST_IDEX_PC_TRAVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ex_pc == $past(ifid_pc)); // R8
  AST_EXMEM_CARRY: assert property (@(posedge clk) disable iff (rst)
    !bubble_exmem |=> (mem_ctl_m == $past(ex_ctl_m) && mem_ctl_wb == $past(ex_ctl_wb))); // R9
  AST_DEST_TRAVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mem_dest == $past(ex_dest) && wb_dest == $past(mem_dest))); // R9
  AST_MEMWB_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!bubble_memwb |=> wb_ctl_wb == $past(mem_ctl_wb))); // R10
  AST_MEMWB_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    bubble_memwb |=> wb_ctl_wb == '0); // R10
endmodule

// File: tb/tb_pipe_stage_regs.sv
module tb_pipe_stage_regs;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_CYCLES   = 2000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst, stall, flush_ifid, bubble_idex, bubble_exmem, bubble_memwb, pc_sel_branch;
  logic [31:0] branch_target, pc_q, imem_instr, ifid_instr, ifid_pc;
  logic [31:0] id_rs_val, id_rt_val, id_imm;
  logic [4:0]  id_dest;
  logic [3:0]  id_ctl_ex;
  logic [2:0]  id_ctl_m;
  logic [1:0]  id_ctl_wb;
  logic [31:0] ex_rs_val, ex_rt_val, ex_imm, ex_pc;
  logic [4:0]  ex_dest;
  logic [3:0]  ex_ctl_ex;
  logic [2:0]  ex_ctl_m;
  logic [1:0]  ex_ctl_wb;
  logic [31:0] ex_alu_res, ex_br_target, ex_store_data;
  logic        ex_zero;
  logic [31:0] mem_alu_res, mem_br_target, mem_store_data, mem_load_data;
  logic        mem_zero;
  logic [4:0]  mem_dest;
  logic [2:0]  mem_ctl_m;
  logic [1:0]  mem_ctl_wb;
  logic [31:0] wb_load_data, wb_alu_res;
  logic [4:0]  wb_dest;
  logic [1:0]  wb_ctl_wb;

  pipe_stage_regs dut (
    .clk(clk), .rst(rst), .stall(stall), .flush_ifid(flush_ifid),
    .bubble_idex(bubble_idex), .bubble_exmem(bubble_exmem), .bubble_memwb(bubble_memwb),
    .pc_sel_branch(pc_sel_branch), .branch_target(branch_target), .pc_q(pc_q),
    .imem_instr(imem_instr), .ifid_instr(ifid_instr), .ifid_pc(ifid_pc),
    .id_rs_val(id_rs_val), .id_rt_val(id_rt_val), .id_imm(id_imm), .id_dest(id_dest),
    .id_ctl_ex(id_ctl_ex), .id_ctl_m(id_ctl_m), .id_ctl_wb(id_ctl_wb),
    .ex_rs_val(ex_rs_val), .ex_rt_val(ex_rt_val), .ex_imm(ex_imm), .ex_pc(ex_pc),
    .ex_dest(ex_dest), .ex_ctl_ex(ex_ctl_ex), .ex_ctl_m(ex_ctl_m), .ex_ctl_wb(ex_ctl_wb),
    .ex_alu_res(ex_alu_res), .ex_br_target(ex_br_target), .ex_zero(ex_zero),
    .ex_store_data(ex_store_data),
    .mem_alu_res(mem_alu_res), .mem_br_target(mem_br_target), .mem_zero(mem_zero),
    .mem_store_data(mem_store_data), .mem_dest(mem_dest), .mem_ctl_m(mem_ctl_m),
    .mem_ctl_wb(mem_ctl_wb), .mem_load_data(mem_load_data),
    .wb_load_data(wb_load_data), .wb_alu_res(wb_alu_res), .wb_dest(wb_dest),
    .wb_ctl_wb(wb_ctl_wb)
  );

  // behavioural reference, one state update per rising edge
  logic [31:0] m_pc, m_if_instr, m_if_pc;
  logic [31:0] m_ex_rs, m_ex_rt, m_ex_imm, m_ex_pc;
  logic [4:0]  m_ex_dest, m_mem_dest, m_wb_dest;
  logic [3:0]  m_ex_cex;
  logic [2:0]  m_ex_cm, m_mem_cm;
  logic [1:0]  m_ex_cwb, m_mem_cwb, m_wb_cwb;
  logic [31:0] m_mem_alu, m_mem_bt, m_mem_sd, m_wb_ld, m_wb_alu;
  logic        m_mem_z;

  always @(posedge clk) begin
    // data paths load every cycle
    m_ex_rs   <= id_rs_val;  m_ex_rt <= id_rt_val; m_ex_imm <= id_imm;
    m_ex_pc   <= m_if_pc;    m_ex_dest <= id_dest;
    m_mem_alu <= ex_alu_res; m_mem_bt <= ex_br_target; m_mem_z <= ex_zero;
    m_mem_sd  <= ex_store_data; m_mem_dest <= m_ex_dest;
    m_wb_ld   <= mem_load_data; m_wb_alu <= m_mem_alu; m_wb_dest <= m_mem_dest;
    if (rst) begin
      m_pc <= 32'd0; m_if_instr <= 32'd0; m_if_pc <= 32'd0;
      m_ex_cex <= '0; m_ex_cm <= '0; m_ex_cwb <= '0;
      m_mem_cm <= '0; m_mem_cwb <= '0; m_wb_cwb <= '0;
    end else begin
      if (pc_sel_branch) m_pc <= branch_target;
      else if (!stall)   m_pc <= m_pc + 32'd4;
      if (flush_ifid) begin
        m_if_instr <= 32'd0; m_if_pc <= m_pc;
      end else if (!stall) begin
        m_if_instr <= imem_instr; m_if_pc <= m_pc;
      end
      if (stall || bubble_idex) begin
        m_ex_cex <= '0; m_ex_cm <= '0; m_ex_cwb <= '0;
      end else begin
        m_ex_cex <= id_ctl_ex; m_ex_cm <= id_ctl_m; m_ex_cwb <= id_ctl_wb;
      end
      m_mem_cm  <= bubble_exmem ? 3'd0 : m_ex_cm;
      m_mem_cwb <= bubble_exmem ? 2'd0 : m_ex_cwb;
      m_wb_cwb  <= bubble_memwb ? 2'd0 : m_mem_cwb;
    end
  end

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 R5 pc_q", pc_q, m_pc);
    chk("R4 R5 R7 ifid_instr", ifid_instr, m_if_instr);
    chk("R4 R7 ifid_pc", ifid_pc, m_if_pc);
    chk("R8 ex_rs_val", ex_rs_val, m_ex_rs);
    chk("R8 ex_rt_val", ex_rt_val, m_ex_rt);
    chk("R8 ex_imm", ex_imm, m_ex_imm);
    chk("R8 ex_pc", ex_pc, m_ex_pc);
    chk("R8 ex_dest", {27'd0, ex_dest}, {27'd0, m_ex_dest});
    chk("R6 R8 ex_ctl", {23'd0, ex_ctl_ex, ex_ctl_m, ex_ctl_wb},
        {23'd0, m_ex_cex, m_ex_cm, m_ex_cwb});
    chk("R9 mem_alu_res", mem_alu_res, m_mem_alu);
    chk("R9 mem_br_target", mem_br_target, m_mem_bt);
    chk("R9 mem_zero_store", mem_store_data ^ {31'd0, mem_zero}, m_mem_sd ^ {31'd0, m_mem_z});
    chk("R9 mem_dest", {27'd0, mem_dest}, {27'd0, m_mem_dest});
    chk("R9 mem_ctl", {27'd0, mem_ctl_m, mem_ctl_wb}, {27'd0, m_mem_cm, m_mem_cwb});
    chk("R10 wb_load_data", wb_load_data, m_wb_ld);
    chk("R10 wb_alu_res", wb_alu_res, m_wb_alu);
    chk("R10 wb_dest", {27'd0, wb_dest}, {27'd0, m_wb_dest});
    chk("R10 wb_ctl_wb", {30'd0, wb_ctl_wb}, {30'd0, m_wb_cwb});
  endtask

  task automatic drive_data();
    imem_instr    = $urandom; branch_target = $urandom & 32'hFFFF_FFFC;
    id_rs_val     = $urandom; id_rt_val = $urandom; id_imm = $urandom;
    id_dest       = 5'($urandom); id_ctl_ex = 4'($urandom);
    id_ctl_m      = 3'($urandom); id_ctl_wb = 2'($urandom);
    ex_alu_res    = $urandom; ex_br_target = $urandom; ex_zero = 1'($urandom);
    ex_store_data = $urandom; mem_load_data = $urandom;
  endtask

  // pct values per phase: stall, flush, redirect, bubbles
  task automatic drive_ctl(input int ps, input int pf, input int pb, input int pbb);
    stall         = ($urandom % 100) < ps;
    flush_ifid    = ($urandom % 100) < pf;
    pc_sel_branch = ($urandom % 100) < pb;
    bubble_idex   = ($urandom % 100) < pbb;
    bubble_exmem  = ($urandom % 100) < pbb;
    bubble_memwb  = ($urandom % 100) < pbb;
  endtask

  initial begin
    rst = 1'b1;
    drive_ctl(0, 0, 0, 0);
    drive_data();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pc_q reset", pc_q, 32'd0);
    chk("R1 ifid_instr reset", ifid_instr, 32'd0);
    chk("R1 ifid_pc reset", ifid_pc, 32'd0);
    chk("R1 ctl reset", {14'd0, ex_ctl_ex, ex_ctl_m, ex_ctl_wb, mem_ctl_m, mem_ctl_wb, wb_ctl_wb},
        32'd0);
    rst = 1'b0;
    for (int cyc = 0; cyc < N_CYCLES; cyc++) begin
      int ph;
      ph = cyc / 250;
      case (ph)
        0:       drive_ctl(0, 0, 0, 0);      // straight flow, R2 R4
        1:       drive_ctl(50, 0, 0, 0);     // stalls only, R5 R6
        2:       drive_ctl(50, 40, 0, 0);    // stall with flush, R7
        3:       drive_ctl(50, 0, 40, 0);    // stall with redirect, R3
        4:       drive_ctl(0, 0, 0, 50);     // bubbles, R6 R9 R10
        default: drive_ctl(30, 20, 20, 30);
      endcase
      drive_data();
      rst = (cyc == 1700);                    // mid-run reset, R1
      @(negedge clk);
      compare_all();
    end
    rst = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule